// File: doc/BRIEF.md
# FIFO threshold interrupt unit

This block sits between a byte-serial shifting engine and software. It holds one byte FIFO for outgoing data and one for incoming data, both `DEPTH` entries deep. Software reaches them through a plain register read/write port; the engine reaches them through push and pop strobes. Software can move data in bursts because the block raises interrupt requests when the fill levels cross programmable trigger points.

Each interrupt cause has a small two-state flag machine. The states are `FLAG_IDLE` and `FLAG_PEND`. The transition `FLAG_IDLE -> FLAG_PEND` is taken when the cause's event is seen. The transition `FLAG_PEND -> FLAG_IDLE` is taken when software writes a one to the flag's status bit. A clear wins over an event that arrives in the same cycle. If the cause is still true, the flag therefore returns one cycle later, so a handler can clear a flag after servicing the FIFO without losing the request. The interrupt output combines every flag that is pending and enabled.

Register offsets on `reg_addr`:

| Offset | Register |
|--------|----------|
| 0 | FIFO control |
| 1 | fill counts |
| 2 | interrupt enable |
| 3 | interrupt status |
| 4 | transmit data |
| 5 | receive data |

Top module: `fifo_irq_unit`

## Requirements
- R1: Bytes written to offset 4 leave on `eng_tx_data` in write order. `eng_tx_valid` is high while the transmit FIFO holds a byte, and each `eng_tx_pop` cycle removes one byte.
- R2: Bytes pushed with `eng_rx_push` read back from offset 5 in push order. Each read of offset 5 with `reg_ren` removes one byte.
- R3: Offset 1 reports the receive count in bits [CW-1:0] and the transmit count in bits [16+CW-1:16], where CW = clog2(DEPTH+1). Each count updates on the clock edge of the push or pop.
- R4: Offset 0 holds the receive trigger level in bits 7:0 and the transmit trigger level in bits 23:16. Both reset to 3/4 of DEPTH.
- R5: A write to offset 0 with bit 15 set empties the receive FIFO, and bit 31 set empties the transmit FIFO. Neither bit is stored or read back.
- R6: Status bit 0 (receive ready) becomes pending one cycle after the receive count is at or above its trigger level.
- R7: Status bit 4 (transmit request) becomes pending one cycle after the transmit count is at or below its trigger level.
- R8: Status bit 8 (receive overflow) becomes pending when a push arrives while the receive FIFO is full. The pushed byte is dropped and the count stays at DEPTH.
- R9: Status bit 12 (transfer complete) becomes pending on the edge after an `eng_done` pulse.
- R10: Writing a one to a status bit clears it, and writing a zero has no effect. A cleared bit whose cause is still true is pending again one cycle later.
- R11: `irq` is high exactly when some status bit is pending and the bit at the same position of offset 2 is set.
- R12: A write to offset 4 while the transmit FIFO is full is dropped. A read of offset 5 while the receive FIFO is empty changes no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wen | input | 1 | register write strobe |
| reg_ren | input | 1 | register read strobe (pops on offset 5) |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| eng_tx_pop | input | 1 | engine takes the head transmit byte |
| eng_tx_valid | output | 1 | transmit FIFO not empty |
| eng_tx_data | output | 8 | head transmit byte |
| eng_rx_push | input | 1 | engine delivers a received byte |
| eng_rx_data | input | 8 | received byte |
| eng_done | input | 1 | one-cycle transfer-complete pulse |
| irq | output | 1 | combined interrupt request |

## Verification
The bench targets the cases below. Each failure mode listed is what a broken design would show.

- **Clear while the cause persists.** A flag cleared with its threshold still met must read zero for one cycle and then return. A design where the event beats the clear would never show the zero. A design that drops the level would lose the request.
- **Threshold edges.** Exactly the trigger count must raise receive ready, and one more byte than the transmit level must keep the transmit request low. An off-by-one compare shows up at these counts.
- **Push into a full receive FIFO.** This must flag overflow and drop the byte. A design that wraps the pointer would instead corrupt the oldest byte in the scoreboard.
- **Flush bits.** The flush bits must zero one FIFO without being stored in the control readback.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

    localparam int NFLAG = 4;

    // flag index order inside the block; bit position in the status word is 4*index
    localparam int F_RXRDY = 0;
    localparam int F_TXREQ = 1;
    localparam int F_RXOVF = 2;
    localparam int F_DONE  = 3;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_CNT  = 3'd1;
    localparam logic [2:0] ADR_IEN  = 3'd2;
    localparam logic [2:0] ADR_ISTA = 3'd3;
    localparam logic [2:0] ADR_TXD  = 3'd4;
    localparam logic [2:0] ADR_RXD  = 3'd5;

    localparam int CTL_RXLVL_LSB = 0;
    localparam int CTL_RXFLUSH   = 15;
    localparam int CTL_TXLVL_LSB = 16;
    localparam int CTL_TXFLUSH   = 31;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;

    function automatic logic [31:0] spread_flags(input logic [NFLAG-1:0] f);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < NFLAG; i++) r[4*i] = f[i];
        return r;
    endfunction

    function automatic logic [NFLAG-1:0] gather_flags(input logic [31:0] w);
        logic [NFLAG-1:0] r;
        for (int i = 0; i < NFLAG; i++) r[i] = w[4*i];
        return r;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_lost
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full && !flush;
    assign do_pop    = pop && !empty && !flush;
    assign push_lost = push && full && !flush;
    assign head      = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/irq_flag.sv
module irq_flag
    import fiu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_in,
    input  logic clear,
    output logic pending
);

    flag_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE: if (event_in) state_nx = FLAG_PEND;
            FLAG_PEND: if (clear)    state_nx = FLAG_IDLE;
            default:                 state_nx = FLAG_IDLE;
        endcase
    end

    always_comb begin
        pending = (state == FLAG_PEND);
    end

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
    import fiu_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = 8,
    localparam int XW   = (CW > LW) ? CW : LW,
    localparam logic [LW-1:0] LVL_RST = LW'((DEPTH / 4) * 3)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic        reg_ren,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_tx_pop,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic        eng_done,
    output logic        irq
);

    logic [LW-1:0]    rx_lvl, tx_lvl;
    logic [NFLAG-1:0] ien_q, sta_q, flag_evt, flag_clr;
    logic [CW-1:0]    rx_cnt, tx_cnt;
    logic [7:0]       rx_head;
    logic             rx_full, rx_empty, rx_lost;
    logic             tx_full, tx_empty, tx_lost;
    logic             wr_ctrl, rx_flush, tx_flush;
    logic             tx_wr, rx_rd;

    assign wr_ctrl  = reg_wen && (reg_addr == ADR_CTRL);
    assign rx_flush = wr_ctrl && reg_wdata[CTL_RXFLUSH];
    assign tx_flush = wr_ctrl && reg_wdata[CTL_TXFLUSH];
    assign tx_wr    = reg_wen && (reg_addr == ADR_TXD);
    assign rx_rd    = reg_ren && (reg_addr == ADR_RXD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_lvl <= LVL_RST;
            tx_lvl <= LVL_RST;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                rx_lvl <= reg_wdata[CTL_RXLVL_LSB +: LW];
                tx_lvl <= reg_wdata[CTL_TXLVL_LSB +: LW];
            end
            if (reg_wen && reg_addr == ADR_IEN) ien_q <= gather_flags(reg_wdata);
        end
    end

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_wr), .push_data(reg_wdata[7:0]), .pop(eng_tx_pop),
        .head(eng_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .push_lost(tx_lost)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_push), .push_data(eng_rx_data), .pop(rx_rd),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .push_lost(rx_lost)
    );

    assign eng_tx_valid = !tx_empty;

    // level and pulse causes feeding the flag machines
    always_comb begin
        flag_evt          = '0;
        flag_evt[F_RXRDY] = XW'(rx_cnt) >= XW'(rx_lvl);
        flag_evt[F_TXREQ] = XW'(tx_cnt) <= XW'(tx_lvl);
        flag_evt[F_RXOVF] = rx_lost;
        flag_evt[F_DONE]  = eng_done;
        flag_clr = (reg_wen && reg_addr == ADR_ISTA) ? gather_flags(reg_wdata) : '0;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        irq_flag u_flag (
            .clk(clk), .rst_n(rst_n), .event_in(flag_evt[g]),
            .clear(flag_clr[g]), .pending(sta_q[g])
        );
    end

    assign irq = |(sta_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CTL_RXLVL_LSB +: LW] = rx_lvl;
                reg_rdata[CTL_TXLVL_LSB +: LW] = tx_lvl;
            end
            ADR_CNT: begin
                reg_rdata[0 +: CW]  = rx_cnt;
                reg_rdata[16 +: CW] = tx_cnt;
            end
            ADR_IEN:  reg_rdata = spread_flags(ien_q);
            ADR_ISTA: reg_rdata = spread_flags(sta_q);
            ADR_RXD:  reg_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = tx_full ^ tx_lost;

endmodule

// File: rtl/fifo_irq_unit_chk.sv
module fifo_irq_unit_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eng_rx_push,
    input logic          eng_done,
    input logic          rx_full,
    input logic          rx_flush,
    input logic [CW-1:0] rx_cnt,
    input logic [3:0]    sta_q,
    input logic [3:0]    ien_q,
    input logic [3:0]    flag_clr,
    input logic          irq
);

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_cnt == '0));

    a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_flush && !flag_clr[2]) |=> sta_q[2]);

    a_r9_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !flag_clr[3]) |=> sta_q[3]);

    a_r10_clear_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_q[0] && flag_clr[0]) |=> !sta_q[0]);

    a_r10_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_q[3] && flag_clr[3]) |=> !sta_q[3]);

    a_r11_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sta_q & ien_q)) |-> irq);

endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .eng_rx_push(eng_rx_push), .eng_done(eng_done),
    .rx_full(rx_full), .rx_flush(rx_flush), .rx_cnt(rx_cnt), .sta_q(sta_q),
    .ien_q(ien_q), .flag_clr(flag_clr), .irq(irq)
);

// File: tb/fifo_irq_unit_tb.sv
module fifo_irq_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0, reg_ren = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_tx_pop = 1'b0, eng_tx_valid;
    logic [7:0]  eng_tx_data;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_irq_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_ren(reg_ren),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_done(eng_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end right after a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_ren = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_ren = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // driver: software side loads the transmit FIFO, expected bytes queued
    task automatic drv_tx(input logic [7:0] b, input bit expect_kept);
        if (expect_kept) txq.push_back(b);
        wr(3'd4, {24'h0, b});
    endtask

    // driver: engine delivers a received byte
    task automatic drv_rx(input logic [7:0] b, input bit expect_kept);
        if (expect_kept) rxq.push_back(b);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    // monitor: engine side takes a transmit byte and compares it
    task automatic mon_tx(input string req);
        logic [7:0] e;
        e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
        chk(req, {31'h0, eng_tx_valid}, 32'h1);
        chk(req, {24'h0, eng_tx_data}, {24'h0, e});
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    // monitor: software side reads a received byte and compares it
    task automatic mon_rx(input string req);
        logic [31:0] d;
        logic [7:0] e;
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
        rd(3'd5, d);
        chk(req, d, {24'h0, e});
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();

        // reset state
        rd(3'd1, d); chk("R3 reset counts", d, 32'h0);
        rd(3'd0, d); chk("R4 reset levels", d, 32'h0030_0030);
        rd(3'd3, d); chk("R7 reset tx request", d, 32'h0000_0010);
        chk("R11 reset irq", {31'h0, irq}, 32'h0);

        // transmit order
        drv_tx(8'hA1, 1); drv_tx(8'hB2, 1); drv_tx(8'hC3, 1);
        rd(3'd1, d); chk("R3 tx count", d, 32'h0003_0000);
        mon_tx("R1 tx order"); mon_tx("R1 tx order"); mon_tx("R1 tx order");
        chk("R1 tx drained", {31'h0, eng_tx_valid}, 32'h0);

        // receive order
        drv_rx(8'h10, 1); drv_rx(8'h20, 1); drv_rx(8'h30, 1);
        rd(3'd1, d); chk("R3 rx count", d, 32'h0000_0003);
        mon_rx("R2 rx order"); mon_rx("R2 rx order"); mon_rx("R2 rx order");
        rd(3'd5, d);
        rd(3'd1, d); chk("R12 empty read", d, 32'h0);

        // receive ready threshold
        wr(3'd0, 32'h0002_0004);
        rd(3'd0, d); chk("R4 level readback", d, 32'h0002_0004);
        drv_rx(8'h41, 1); drv_rx(8'h42, 1); drv_rx(8'h43, 1);
        idle();
        rd(3'd3, d); chk("R6 below level", d & 32'h1, 32'h0);
        drv_rx(8'h44, 1);
        idle();
        rd(3'd3, d); chk("R6 at level", d & 32'h1, 32'h1);

        // write-one-to-clear with cause still present
        wr(3'd3, 32'h1);
        rd(3'd3, d); chk("R10 cleared", d & 32'h1, 32'h0);
        rd(3'd3, d); chk("R10 reasserted", d & 32'h1, 32'h1);
        wr(3'd3, 32'h0);
        rd(3'd3, d); chk("R10 zero write", d & 32'h1, 32'h1);

        // interrupt combine
        chk("R11 disabled", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h1);
        rd(3'd2, d); chk("R11 enable readback", d, 32'h1);
        chk("R11 enabled", {31'h0, irq}, 32'h1);
        repeat (4) mon_rx("R2 rx order");
        wr(3'd3, 32'h1);
        idle();
        chk("R11 cleared", {31'h0, irq}, 32'h0);

        // transmit request threshold (level 2)
        drv_tx(8'h51, 1); drv_tx(8'h52, 1); drv_tx(8'h53, 1);
        wr(3'd3, 32'h10);
        idle();
        rd(3'd3, d); chk("R7 above level", d & 32'h10, 32'h0);
        mon_tx("R1 tx order");
        idle();
        rd(3'd3, d); chk("R7 at level", d & 32'h10, 32'h10);

        // flush transmit and receive
        wr(3'd0, 32'h8002_0004);
        txq.delete();
        rd(3'd1, d); chk("R5 tx flush", d, 32'h0);
        rd(3'd0, d); chk("R5 flush bit not kept", d, 32'h0002_0004);
        drv_rx(8'h61, 0); drv_rx(8'h62, 0);
        wr(3'd0, 32'h0002_8004);
        rd(3'd1, d); chk("R5 rx flush", d, 32'h0);

        // receive overflow
        wr(3'd3, 32'hFFFF_FFFF);
        for (int i = 0; i < DEPTH; i++) drv_rx(8'(i + 8'h80), 1);
        rd(3'd3, d); chk("R8 no overflow at full", d & 32'h100, 32'h0);
        drv_rx(8'hEE, 0);
        rd(3'd3, d); chk("R8 overflow flag", d & 32'h100, 32'h100);
        rd(3'd1, d); chk("R8 count held", d, 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) mon_rx("R8 byte dropped");

        // transmit write while full
        for (int i = 0; i < DEPTH; i++) drv_tx(8'(i + 8'h20), 1);
        drv_tx(8'hDD, 0);
        rd(3'd1, d); chk("R12 tx full count", d, 32'(DEPTH) << 16);
        for (int i = 0; i < DEPTH; i++) mon_tx("R12 tx write dropped");

        // transfer complete
        wr(3'd2, 32'h1000);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        rd(3'd3, d); chk("R9 done flag", d & 32'h1000, 32'h1000);
        chk("R11 done irq", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h1000);
        idle();
        rd(3'd3, d); chk("R9 done cleared", d & 32'h1000, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule